// File: doc/BRIEF.md
# Stochastic-Rounding SGD Weight-Update Datapath

This block applies one stochastic gradient descent update to one parameter per clock cycle. It works only in a 16-bit floating-point format. It takes the current weight, its gradient and its momentum, together with three scalar coefficients: the regularisation strength, the momentum factor and the learning rate. It returns the new weight and the new momentum. There is no wider shadow copy of the weight: the 16-bit weight is the master copy.

The update is done as three chained multiply-add steps:

- decay the gradient, `g' = lambda*w + g`;
- fold the result into the momentum, `v' = mu*v + g'`;
- move the weight, `w' = w - lr*v'`.

Each step produces its exact sum and then rounds it once to 16 bits by stochastic rounding. Small updates therefore survive on average instead of being lost to round-to-nearest. Each step draws its random bits from its own 16-bit linear-feedback shift register. All three registers can be re-seeded together, so a run can be repeated exactly.

The datapath is a three-stage pipeline with a valid flag. It accepts one element every cycle, with no back-pressure.

Top module: `sr_weight_update`

## Requirements
- R1: Every value is 16 bits: sign in bit 15, a 6-bit biased exponent in bits 14:9 (bias 31) and a 9-bit fraction in bits 8:0 with an implied leading one. An exponent field of 0 means zero, whatever the fraction bits hold. Exponent 63 is an ordinary finite exponent; there is no infinity or NaN.
- R2: For each element, the block computes `g' = lambda*w + g`, then `v' = mu*v + g'`, then `w' = (-lr)*v' + w`. Each step is one multiply-add with a single rounding. `v_out` carries v' and `w_out` carries w'.
- R3: In each step the product is formed exactly. The product and the addend are placed on a common grid whose least significant bit lies 46 bit positions below the top bit position of the larger of the two terms. Bits that fall below that grid are dropped toward zero before the signed addition.
- R4: The magnitude of the sum is normalised. The block keeps the 10-bit significand and adds the next 16 bits to the 16-bit random word. A carry out of that addition increments the significand; a significand that overflows becomes 1.0 with the exponent raised by one. All lower bits are dropped. A sum whose 16 bits below the significand are all zero is returned exactly.
- R5: A rounded result whose biased exponent would exceed 63 saturates to the largest finite magnitude (0x7FFF or 0xFFFF) and keeps its sign.
- R6: An exact zero sum, or a rounded result whose biased exponent would be below 1, is returned as +0 (0x0000).
- R7: Each step has its own 16-bit random generator, with next state = (s >> 1) XOR (s[0] ? 0xB400 : 0). A step uses the current state for its rounding, and the state advances once in every cycle in which that step takes an element. The state is never zero.
- R8: A `seed_load` cycle loads generator k (k = 0, 1, 2 for the three steps in order) with `seed_val` XOR salt_k, where the salts are 0x0000, 0x5A5A and 0xC3C3. A loaded value of zero is replaced by 0x0001. A load takes precedence over an advance. After reset the generators hold 0xACE1 XOR salt_k. Loading the same seed again reproduces the same outputs.
- R9: The block accepts one element per cycle. An element presented with `in_valid` at a rising edge appears with `out_valid` after the third rising edge, counting the one that captured it. While `out_valid` is low, `w_out` and `v_out` keep their previous values.
- R10: While `rst_n` is low at a rising edge, `out_valid`, `w_out` and `v_out` go to zero at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| seed_load | input | 1 | Loads all three random generators from `seed_val` |
| seed_val | input | 16 | Seed value |
| in_valid | input | 1 | Marks a valid element on the data inputs |
| w_in | input | 16 | Current weight |
| g_in | input | 16 | Gradient |
| v_in | input | 16 | Current momentum |
| lambda_in | input | 16 | Regularisation coefficient |
| mu_in | input | 16 | Momentum coefficient |
| lr_in | input | 16 | Learning rate |
| out_valid | output | 1 | Marks a valid result |
| w_out | output | 16 | Updated weight |
| v_out | output | 16 | Updated momentum |

## Verification
The hardest behaviour to reach from the ports is the stochastic choice between the two neighbouring 16-bit values. It only shows when a sum is inexact, and the choice depends on the random state, which is hidden. The stimulus repeatedly sends a gradient of 1.0 plus a quarter-ulp regularisation term. It counts how often the larger neighbour appears, then reloads one seed twice and requires identical output streams. Saturation, flush-to-zero, exact cancellation and far-apart operands are reached with directed operand pairs. A long random stream is compared every cycle against a behavioural model that includes the three generators.

// File: rtl/sr_pkg.sv
// Package sr_pkg
// Shared number-format constants, the packed 16-bit float type and the
// generator helper functions for the stochastic-rounding update datapath.
// Assumes: a single 1/6/9 format; no infinity or NaN encodings.
package sr_pkg;

    localparam int EXP_W   = 6;
    localparam int MAN_W   = 9;
    localparam int FP_W    = 1 + EXP_W + MAN_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int SIG_W   = MAN_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int RND_W   = 16;
    localparam int WIN_W   = 46;
    localparam int N_STEP  = 3;

    localparam logic [RND_W-1:0] LFSR_TAPS = 16'hB400;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_t;

    // Per-step salt applied to seeds so the three generators differ.
    function automatic logic [RND_W-1:0] step_salt(input int idx);
        case (idx)
            1:       step_salt = 16'h5A5A;
            2:       step_salt = 16'hC3C3;
            default: step_salt = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/sr_lfsr.sv
// Module sr_lfsr
// Galois linear-feedback shift register used as the random source of one
// rounding step. The state is loadable and advances once per step_en.
// Assumes: INIT is non-zero; a zero load value is replaced by one.
module sr_lfsr #(
    parameter int               WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS  = 16'hB400,
    parameter logic [WIDTH-1:0] INIT  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             step_en,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] load_fixed;

    // Replace a zero seed so the register never locks up.
    always_comb begin
        load_fixed = (load_val == '0) ? WIDTH'(1) : load_val;
    end

    // State update: reset, then load, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= INIT;
        end else if (load_en) begin
            state <= load_fixed;
        end else if (step_en) begin
            state <= (state >> 1) ^ (state[0] ? TAPS : '0);
        end
    end

endmodule

// File: rtl/sr_fma_round.sv
// Module sr_fma_round
// Combinational multiply-add, result = mul_a * mul_b + add_c, with a single
// stochastic rounding to the 16-bit format. The product is exact. Both terms
// are placed on a grid WIN_W bits below the top of the larger term; bits under
// that grid are dropped. The 16 bits under the kept significand are added to
// rnd, and the carry decides the rounding direction.
// Assumes: exponent 0 encodes zero; overflow saturates; underflow flushes.
module sr_fma_round
    import sr_pkg::*;
(
    input  fp_t              mul_a,
    input  fp_t              mul_b,
    input  fp_t              add_c,
    input  logic [RND_W-1:0] rnd,
    output fp_t              result
);

    localparam int ACC_W = WIN_W + 2;

    logic              prod_zero;
    logic              add_zero;
    logic              prod_neg;
    logic [PROD_W-1:0] prod_sig;
    logic [SIG_W-1:0]  add_sig;
    int                lsb_p;
    int                lsb_c;
    int                top_pos;
    int                base;
    int                sh_p;
    int                sh_c;
    logic [ACC_W-1:0]  p_mag;
    logic [ACC_W-1:0]  c_mag;
    logic [ACC_W-1:0]  sum_u;
    logic [ACC_W-1:0]  mag;
    logic              r_sgn;
    int                lead;
    logic [SIG_W-1:0]  sig;
    logic [RND_W-1:0]  disc;
    logic              carry;
    logic [MAN_W-1:0]  man_r;
    int                e_res;

    // Exact product and addend placed on the common grid.
    always_comb begin
        prod_zero = (mul_a.exp == '0) || (mul_b.exp == '0);
        add_zero  = (add_c.exp == '0);
        prod_neg  = mul_a.sgn ^ mul_b.sgn;
        prod_sig  = PROD_W'({1'b1, mul_a.man}) * PROD_W'({1'b1, mul_b.man});
        add_sig   = {1'b1, add_c.man};
        lsb_p     = int'(mul_a.exp) + int'(mul_b.exp) - 2 * BIAS - 2 * MAN_W;
        lsb_c     = int'(add_c.exp) - BIAS - MAN_W;
        if (prod_zero) begin
            top_pos = lsb_c + SIG_W;
        end else if (add_zero) begin
            top_pos = lsb_p + PROD_W;
        end else if (lsb_p + PROD_W > lsb_c + SIG_W) begin
            top_pos = lsb_p + PROD_W;
        end else begin
            top_pos = lsb_c + SIG_W;
        end
        base = top_pos - WIN_W;
        sh_p = lsb_p - base;
        sh_c = lsb_c - base;
        if (prod_zero) begin
            p_mag = '0;
        end else if (sh_p >= 0) begin
            p_mag = ACC_W'(prod_sig) << sh_p;
        end else begin
            p_mag = ACC_W'(prod_sig) >> (-sh_p);
        end
        if (add_zero) begin
            c_mag = '0;
        end else if (sh_c >= 0) begin
            c_mag = ACC_W'(add_sig) << sh_c;
        end else begin
            c_mag = ACC_W'(add_sig) >> (-sh_c);
        end
    end

    // Signed sum, magnitude and position of the leading one.
    always_comb begin
        sum_u = (prod_neg ? -p_mag : p_mag) + (add_c.sgn ? -c_mag : c_mag);
        r_sgn = sum_u[ACC_W-1];
        mag   = r_sgn ? -sum_u : sum_u;
        lead  = 0;
        for (int i = 0; i < ACC_W; i++) begin
            if (mag[i]) begin
                lead = i;
            end
        end
    end

    // Normalise, add the random word to the discarded field, and pack.
    always_comb begin
        sig   = SIG_W'((mag << (ACC_W - 1 - lead)) >> (ACC_W - SIG_W));
        disc  = RND_W'((mag << (ACC_W - 1 - lead)) >> (ACC_W - SIG_W - RND_W));
        carry = ({1'b0, disc} + {1'b0, rnd}) > {1'b0, {RND_W{1'b1}}};
        man_r = sig[MAN_W-1:0] + MAN_W'(carry);
        e_res = lead + base + BIAS + ((carry && (&sig)) ? 1 : 0);
        if (mag == '0) begin
            result = '0;
        end else if (e_res > EXP_MAX) begin
            result = '{sgn: r_sgn, exp: '1, man: '1};
        end else if (e_res < 1) begin
            result = '0;
        end else begin
            result = '{sgn: r_sgn, exp: EXP_W'(e_res), man: man_r};
        end
    end

endmodule

// File: rtl/sr_weight_update.sv
// Module sr_weight_update
// Three-stage weight-update pipeline: gradient decay, momentum fold, weight
// step. Each stage is one stochastically rounded multiply-add. Each stage has
// its own random generator, which advances when the stage takes an element.
// Assumes: one element per cycle, no stall; seeds are reloaded while idle.
module sr_weight_update
    import sr_pkg::*;
#(
    parameter logic [RND_W-1:0] RESET_SEED = 16'hACE1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seed_load,
    input  logic [RND_W-1:0] seed_val,
    input  logic            in_valid,
    input  logic [FP_W-1:0] w_in,
    input  logic [FP_W-1:0] g_in,
    input  logic [FP_W-1:0] v_in,
    input  logic [FP_W-1:0] lambda_in,
    input  logic [FP_W-1:0] mu_in,
    input  logic [FP_W-1:0] lr_in,
    output logic            out_valid,
    output logic [FP_W-1:0] w_out,
    output logic [FP_W-1:0] v_out
);

    logic [N_STEP-1:0][RND_W-1:0] rnd_q;
    logic [N_STEP-1:0]            step_vec;

    logic s1_valid;
    fp_t  s1_g;
    fp_t  s1_w;
    fp_t  s1_v;
    fp_t  s1_mu;
    fp_t  s1_lr;

    logic s2_valid;
    fp_t  s2_v;
    fp_t  s2_w;
    fp_t  s2_lr;

    fp_t  g_new;
    fp_t  v_new;
    fp_t  w_new;
    fp_t  neg_lr;

    // Each generator steps when its own stage consumes an element.
    always_comb begin
        step_vec = {s2_valid, s1_valid, in_valid};
        neg_lr   = '{sgn: ~s2_lr.sgn, exp: s2_lr.exp, man: s2_lr.man};
    end

    for (genvar k = 0; k < N_STEP; k++) begin : g_rng
        sr_lfsr #(
            .WIDTH (RND_W),
            .TAPS  (LFSR_TAPS),
            .INIT  (RESET_SEED ^ step_salt(k))
        ) u_rng (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (seed_load),
            .load_val (seed_val ^ step_salt(k)),
            .step_en  (step_vec[k]),
            .state    (rnd_q[k])
        );
    end

    sr_fma_round u_decay (
        .mul_a  (fp_t'(lambda_in)),
        .mul_b  (fp_t'(w_in)),
        .add_c  (fp_t'(g_in)),
        .rnd    (rnd_q[0]),
        .result (g_new)
    );

    sr_fma_round u_moment (
        .mul_a  (s1_mu),
        .mul_b  (s1_v),
        .add_c  (s1_g),
        .rnd    (rnd_q[1]),
        .result (v_new)
    );

    sr_fma_round u_step (
        .mul_a  (neg_lr),
        .mul_b  (s2_v),
        .add_c  (s2_w),
        .rnd    (rnd_q[2]),
        .result (w_new)
    );

    // Stage 1 register: decayed gradient plus operands for later stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_g     <= '0;
            s1_w     <= '0;
            s1_v     <= '0;
            s1_mu    <= '0;
            s1_lr    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_g  <= g_new;
                s1_w  <= fp_t'(w_in);
                s1_v  <= fp_t'(v_in);
                s1_mu <= fp_t'(mu_in);
                s1_lr <= fp_t'(lr_in);
            end
        end
    end

    // Stage 2 register: new momentum plus weight and rate for the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_v     <= '0;
            s2_w     <= '0;
            s2_lr    <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_v  <= v_new;
                s2_w  <= s1_w;
                s2_lr <= s1_lr;
            end
        end
    end

    // Output register: holds the last result while no element completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            w_out     <= '0;
            v_out     <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                w_out <= w_new;
                v_out <= s2_v;
            end
        end
    end

endmodule

// File: rtl/sr_update_chk.sv
// Module sr_update_chk
// Property checker for sr_weight_update, attached by bind. It checks the
// pipeline latency, output hold, the canonical zero form, generator health
// and the reset values.
// Assumes: the synchronous active-low reset is asserted from time zero.
module sr_update_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_valid,
    input logic [15:0] w_out,
    input logic [15:0] v_out,
    input logic [47:0] rng_flat
);

    logic [2:0] vpipe;

    // Independent shift record of accepted elements.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[1:0], in_valid};
        end
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[2]);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(w_out) && $stable(v_out)));

    // R6
    w_zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_out[14:9] == 6'd0) |-> (w_out == 16'h0000));

    // R6
    v_zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_out[14:9] == 6'd0) |-> (v_out == 16'h0000));

    // R7
    rng_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rng_flat[15:0] != 16'h0) && (rng_flat[31:16] != 16'h0) && (rng_flat[47:32] != 16'h0));

    // R10
    reset_out_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && (w_out == 16'h0) && (v_out == 16'h0)));

endmodule

bind sr_weight_update sr_update_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .w_out     (w_out),
    .v_out     (v_out),
    .rng_flat  (rnd_q)
);

// File: tb/sr_weight_update_tb.sv
// Bench for sr_weight_update: behavioural cycle model plus directed cases.
module sr_weight_update_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [15:0] seed_val = 16'h0;
    logic        in_valid = 1'b0;
    logic [15:0] w_in = 16'h0, g_in = 16'h0, v_in = 16'h0;
    logic [15:0] lambda_in = 16'h0, mu_in = 16'h0, lr_in = 16'h0;
    logic        out_valid;
    logic [15:0] w_out, v_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sr_weight_update u_dut (
        .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
        .in_valid(in_valid), .w_in(w_in), .g_in(g_in), .v_in(v_in),
        .lambda_in(lambda_in), .mu_in(mu_in), .lr_in(lr_in),
        .out_valid(out_valid), .w_out(w_out), .v_out(v_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- reference arithmetic (from R1-style format rules) ----
    function automatic longint place(input longint v, input int sh);
        if (sh >= 0) return v << sh;
        if (-sh >= 63) return 0;
        return v >> (-sh);
    endfunction

    function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b,
                                            input logic [15:0] c, input logic [15:0] r);
        bit pz, cz, neg, cy;
        longint pm, mc, pi, ci, s, m;
        int lp, lc, top, base, k, e;
        logic [63:0] n;
        logic [9:0] sg;
        logic [15:0] dc;
        pz = (a[14:9] == 0) || (b[14:9] == 0);
        cz = (c[14:9] == 0);
        if (pz && cz) return 16'h0000;
        pm = longint'({1'b1, a[8:0]}) * longint'({1'b1, b[8:0]});
        mc = longint'({1'b1, c[8:0]});
        lp = int'(a[14:9]) + int'(b[14:9]) - 80;
        lc = int'(c[14:9]) - 40;
        if (pz) top = lc + 10;
        else if (cz) top = lp + 20;
        else top = (lp + 20 > lc + 10) ? lp + 20 : lc + 10;
        base = top - 46;
        pi = pz ? 0 : place(pm, lp - base);
        ci = cz ? 0 : place(mc, lc - base);
        if (a[15] ^ b[15]) pi = -pi;
        if (c[15]) ci = -ci;
        s = pi + ci;
        if (s == 0) return 16'h0000;
        neg = (s < 0);
        m = neg ? -s : s;
        k = 0;
        for (int i = 0; i < 63; i++) if (m[i]) k = i;
        n = 64'(m) << (63 - k);
        sg = n[63:54];
        dc = n[53:38];
        cy = (int'(dc) + int'(r)) > 65535;
        e = k + base + 31;
        if (cy) begin
            if (sg == 10'h3FF) begin sg = 10'h200; e++; end
            else sg = sg + 10'd1;
        end
        if (e > 63) return {neg, 15'h7FFF};
        if (e < 1) return 16'h0000;
        return {neg, e[5:0], sg[8:0]};
    endfunction

    function automatic logic [15:0] salt(input int k);
        return (k == 1) ? 16'h5A5A : (k == 2) ? 16'hC3C3 : 16'h0000;
    endfunction

    // ---------------- cycle model ----------------
    logic [15:0] L [3];
    logic        m_s1_v = 0, m_s2_v = 0, m_ov = 0;
    logic [15:0] m_s1_g = 0, m_s1_w = 0, m_s1_vv = 0, m_s1_mu = 0, m_s1_lr = 0;
    logic [15:0] m_s2_vv = 0, m_s2_w = 0, m_s2_lr = 0;
    logic [15:0] m_w = 0, m_v = 0;

    always @(posedge clk) begin
        logic [2:0] st;
        logic [15:0] r0, r1, r2, sv;
        if (!rst_n) begin
            m_s1_v = 0; m_s2_v = 0; m_ov = 0; m_w = 0; m_v = 0;
            for (int k = 0; k < 3; k++) L[k] = 16'hACE1 ^ salt(k);
        end else begin
            st = {m_s2_v, m_s1_v, in_valid};
            r0 = L[0]; r1 = L[1]; r2 = L[2];
            if (m_s2_v) begin
                m_w = ref_fma({~m_s2_lr[15], m_s2_lr[14:0]}, m_s2_vv, m_s2_w, r2);
                m_v = m_s2_vv;
            end
            m_ov = m_s2_v;
            if (m_s1_v) begin
                m_s2_vv = ref_fma(m_s1_mu, m_s1_vv, m_s1_g, r1);
                m_s2_w = m_s1_w;
                m_s2_lr = m_s1_lr;
            end
            m_s2_v = m_s1_v;
            if (in_valid) begin
                m_s1_g = ref_fma(lambda_in, w_in, g_in, r0);
                m_s1_w = w_in; m_s1_vv = v_in; m_s1_mu = mu_in; m_s1_lr = lr_in;
            end
            m_s1_v = in_valid;
            for (int k = 0; k < 3; k++) begin
                if (seed_load) begin
                    sv = seed_val ^ salt(k);
                    L[k] = (sv == 16'h0) ? 16'h0001 : sv;
                end else if (st[k]) begin
                    L[k] = (L[k] >> 1) ^ (L[k][0] ? 16'hB400 : 16'h0000);
                end
            end
        end
    end

    // Every-cycle comparison against the model; also records outputs.
    logic [31:0] obs [$];
    always @(negedge clk) begin
        if (rst_n) begin
            chk(out_valid == m_ov, "R9 out_valid timing", {31'b0, out_valid}, {31'b0, m_ov});
            chk({w_out, v_out} == {m_w, m_v}, m_ov ? "R2 result vs model" : "R9 hold",
                {w_out, v_out}, {m_w, m_v});
            if (out_valid) obs.push_back({w_out, v_out});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drive(input logic [15:0] w, g, v, lam, mu, lr);
        w_in = w; g_in = g; v_in = v; lambda_in = lam; mu_in = mu; lr_in = lr;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_one(input logic [15:0] w, g, v, lam, mu, lr, output logic [31:0] res);
        obs.delete();
        drive(w, g, v, lam, mu, lr);
        repeat (5) @(negedge clk);
        res = (obs.size() > 0) ? obs.pop_front() : 32'hDEADDEAD;
    endtask

    task automatic load_seed(input logic [15:0] s);
        seed_val = s; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
    endtask

    function automatic logic [15:0] rnd_fp(input bit wide);
        logic [5:0] e;
        e = wide ? 6'($urandom_range(0, 63)) : 6'($urandom_range(18, 44));
        return {1'($urandom), e, 9'($urandom)};
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] res;
        logic [31:0] runA [40];
        int ups;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(!out_valid && w_out == 0 && v_out == 0, "R10 reset outputs", {w_out, v_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: exact chain 1.0 - 0.5*(0 + 0.5) = 0.75, v' = 0.5
        run_one(16'h3E00, 16'h3C00, 16'h0000, 16'h0000, 16'h0000, 16'h3C00, res);
        chk(res == {16'h3D00, 16'h3C00}, "R2 exact chain", res, {16'h3D00, 16'h3C00});

        // R2: momentum fold 0.5*1.0 + 0.5 = 1.0; w = 1.0 - 1.0*1.0 -> 0
        run_one(16'h3E00, 16'h3C00, 16'h3E00, 16'h0000, 16'h3C00, 16'h3E00, res);
        chk(res == {16'h0000, 16'h3E00}, "R2 momentum and cancel", res, {16'h0000, 16'h3E00});

        // R1: exponent field 0 with non-zero fraction is zero
        run_one(16'h01FF, 16'h3E00, 16'h0000, 16'h3E00, 16'h0000, 16'h0000, res);
        chk(res[15:0] == 16'h3E00, "R1 zero encoding", res, {16'h01FF, 16'h3E00});

        // R5: positive and negative saturation
        run_one(16'h7FFF, 16'h0000, 16'h0000, 16'h7FFF, 16'h0000, 16'h0000, res);
        chk(res == {16'h7FFF, 16'h7FFF}, "R5 saturate positive", res, {16'h7FFF, 16'h7FFF});
        run_one(16'h7FFF, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, res);
        chk(res[15:0] == 16'hFFFF, "R5 saturate negative", res, {16'h7FFF, 16'hFFFF});

        // R6: underflow flush and exact cancellation
        run_one(16'h0200, 16'h0000, 16'h0000, 16'h3C00, 16'h0000, 16'h0000, res);
        chk(res == {16'h0200, 16'h0000}, "R6 flush to zero", res, {16'h0200, 16'h0000});
        run_one(16'h3F00, 16'hBF00, 16'h0000, 16'h3E00, 16'h0000, 16'h0000, res);
        chk(res[15:0] == 16'h0000, "R6 exact cancel", res, {16'h3F00, 16'h0000});

        // R3: a term far below the grid is dropped: 1.0 - 2^-50 gives 1.0
        run_one(16'h0C00, 16'h3E00, 16'h0000, 16'h8C00, 16'h0000, 16'h0000, res);
        chk(res[15:0] == 16'h3E00, "R3 below-grid term dropped", res, {16'h0C00, 16'h3E00});

        // R4: 1.0 + quarter ulp rounds up in roughly a quarter of cases
        ups = 0;
        obs.delete();
        for (int i = 0; i < 200; i++) drive(16'h3E00, 16'h3E00, 16'h0, 16'h2800, 16'h0, 16'h0);
        repeat (5) @(negedge clk);
        chk(obs.size() == 200, "R9 one element per cycle", obs.size(), 200);
        foreach (obs[i]) begin
            if (obs[i][15:0] == 16'h3E01) ups++;
            else chk(obs[i][15:0] == 16'h3E00, "R4 neighbour values", obs[i], 32'h3E00);
        end
        chk(ups >= 20 && ups <= 80, "R4 stochastic up-rate", ups, 50);

        // R7 R8: same seed reproduces the stream
        load_seed(16'h1234);
        obs.delete();
        for (int i = 0; i < 40; i++) drive(16'h3E00, 16'h3E00, 16'h3C55, 16'h2800, 16'h3B11, 16'h3203);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 40; i++) runA[i] = (obs.size() > 0) ? obs.pop_front() : 32'hX;
        load_seed(16'h1234);
        obs.delete();
        for (int i = 0; i < 40; i++) drive(16'h3E00, 16'h3E00, 16'h3C55, 16'h2800, 16'h3B11, 16'h3203);
        repeat (5) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            res = (obs.size() > 0) ? obs.pop_front() : 32'hDEADDEAD;
            chk(res == runA[i], "R8 seed reproducibility", res, runA[i]);
        end

        // R8: zero seed is usable (model substitutes one)
        load_seed(16'h0000);
        for (int i = 0; i < 30; i++) drive(16'h3E00, 16'h3E00, 16'h0, 16'h2800, 16'h0, 16'h0);
        repeat (5) @(negedge clk);

        // R2 R4 R7: random stream with gaps, compared by the model every cycle
        for (int i = 0; i < 3000; i++) begin
            bit wide;
            wide = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 4) == 0) @(negedge clk);
            drive(rnd_fp(wide), rnd_fp(wide), rnd_fp(wide), rnd_fp(wide), rnd_fp(wide), rnd_fp(wide));
        end
        repeat (6) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule